// File: doc/BRIEF.md
# SPI Pad Test-Mode Control Register

This block is a 32-bit memory-mapped register that lets software drive and observe the pads of an SPI controller directly while the chip is in a system-test mode. It covers four chip-select pads, one clock pad and two data pads. Each pad has a direction that software sets. A pad set to output is driven with a value that software writes. A pad set to input is observed: its live level, passed through a two-flop synchronizer, appears in the readback.

The chip-select pads and the clock pad share one direction bit. Each data pad has a direction bit of its own. A stored set-all-status bit asks the interrupt-status register to set all of its bits, and while it is set it also blocks every status clear. When the test-mode input is low, the pads carry the outputs and enables of the functional SPI engine unchanged, and the register itself can still be written and read.

Top module: `spi_pad_test_reg`

## Requirements
- R1: Register bits 31 to 12 and bit 7 always read as 0, whatever was written to them.
- R2: After reset every stored field is 0: the readback is 0, and in test mode all seven pads are enabled as outputs and driven low.
- R3: Bit 10 is the direction of the chip-select pads (value bits 3 to 0) and the clock pad (value bit 6), with 0 meaning output and 1 meaning input. In test mode each of these pads has its output enable equal to the inverse of bit 10, and the enable updates on the clock edge that stores the write.
- R4: Bit 9 is the direction of data pad 1 (value bit 5) and bit 8 is the direction of data pad 0 (value bit 4), with 0 meaning output and 1 meaning input. In test mode each data pad's output enable is the inverse of its direction bit.
- R5: For a pad whose direction is output, a write stores its value bit. In test mode the pad is driven with the stored value from the next edge on, and the readback returns the stored value.
- R6: For a pad whose direction is input, its readback bit returns the pad level after two synchronizer flops, that is, the level from at least two clock edges earlier.
- R7: A write to the value bit of a pad whose direction is input is ignored, and the stored value is kept. The write is judged against the direction held before the write, so a write that changes a direction in the same access is masked or accepted by the old direction.
- R8: Bit 11 is stored and reads back as written. While it is 1, both the set-all-status request and the status-clear block are asserted. While it is 0, both are low.
- R9: While the test-mode input is low, every pad output and output enable equals the corresponding functional-engine input. Register writes still update the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testMode | input | 1 | System-test mode; when high the register owns the pads |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register readback |
| engCsOut | input | 4 | Engine chip-select output values |
| engCsOe | input | 4 | Engine chip-select output enables |
| engClkOut | input | 1 | Engine clock output value |
| engClkOe | input | 1 | Engine clock output enable |
| engDatOut | input | 2 | Engine data output values |
| engDatOe | input | 2 | Engine data output enables |
| csIn | input | 4 | Chip-select pad input levels |
| clkIn | input | 1 | Clock pad input level |
| datIn | input | 2 | Data pad input levels |
| csOut | output | 4 | Chip-select pad output values |
| csOe | output | 4 | Chip-select pad output enables |
| clkOut | output | 1 | Clock pad output value |
| clkOe | output | 1 | Clock pad output enable |
| datOut | output | 2 | Data pad output values |
| datOe | output | 2 | Data pad output enables |
| setAllStatus | output | 1 | Request to set every interrupt-status bit |
| blockStatusClr | output | 1 | Blocks interrupt-status clears |

## Verification
A direction change and a value write to the same pad can land in one write cycle. The value mask must then follow the direction held before the write. The sweep provokes this on most accesses: it writes a direction code that differs from the previous one together with a fresh value pattern. A bench model that applies the old direction decides which value bits should have been kept. The pad outputs and the readback are compared after the synchronizer has settled, in both test mode and functional mode.

// File: rtl/spi_pad_test_pkg.sv
package spi_pad_test_pkg;
  localparam int CS_LINES  = 4;
  localparam int DAT_LINES = 2;
  localparam int REG_W     = 32;

  // Register layout derived from the line counts.
  localparam int CS_LSB    = 0;
  localparam int DAT_LSB   = CS_LSB + CS_LINES;
  localparam int CLK_BIT   = DAT_LSB + DAT_LINES;
  localparam int RSV_BIT   = CLK_BIT + 1;
  localparam int DIR_LSB   = RSV_BIT + 1;
  localparam int CSDIR_BIT = DIR_LSB + DAT_LINES;
  localparam int SSB_BIT   = CSDIR_BIT + 1;
  localparam int USED_W    = SSB_BIT + 1;
  localparam int PAD_IN_W  = CS_LINES + DAT_LINES + 1;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 cfgLd;
    logic [CS_LINES-1:0]  csLd;
    logic                 clkLd;
    logic [DAT_LINES-1:0] datLd;
  } padStrobe_t;
endpackage

// File: rtl/spi_pad_sync.sv
module spi_pad_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/spi_pad_test_ctrl.sv
module spi_pad_test_ctrl
  import spi_pad_test_pkg::*;
(
  input  logic                 wrEn,
  input  logic                 csClkDir,
  input  logic [DAT_LINES-1:0] datDir,
  output padStrobe_t           strobe
);
  // Value loads are masked by the direction held before this write.
  always_comb begin
    strobe.cfgLd = wrEn;
    strobe.csLd  = {CS_LINES{wrEn & ~csClkDir}};
    strobe.clkLd = wrEn & ~csClkDir;
    strobe.datLd = {DAT_LINES{wrEn}} & ~datDir;
  end
endmodule

// File: rtl/spi_pad_test_dp.sv
module spi_pad_test_dp
  import spi_pad_test_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 testMode,
  input  padStrobe_t           strobe,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  output logic                 csClkDir,
  output logic [DAT_LINES-1:0] datDir,
  input  logic [CS_LINES-1:0]  engCsOut,
  input  logic [CS_LINES-1:0]  engCsOe,
  input  logic                 engClkOut,
  input  logic                 engClkOe,
  input  logic [DAT_LINES-1:0] engDatOut,
  input  logic [DAT_LINES-1:0] engDatOe,
  input  logic [CS_LINES-1:0]  csIn,
  input  logic                 clkIn,
  input  logic [DAT_LINES-1:0] datIn,
  output logic [CS_LINES-1:0]  csOut,
  output logic [CS_LINES-1:0]  csOe,
  output logic                 clkOut,
  output logic                 clkOe,
  output logic [DAT_LINES-1:0] datOut,
  output logic [DAT_LINES-1:0] datOe,
  output logic                 setAllStatus,
  output logic                 blockStatusClr
);
  logic [CS_LINES-1:0]  csVal;
  logic                 clkVal;
  logic [DAT_LINES-1:0] datVal;
  logic                 ssb;
  logic [PAD_IN_W-1:0]  padSync;
  logic [CS_LINES-1:0]  csSync;
  logic                 clkSync;
  logic [DAT_LINES-1:0] datSync;
  logic                 unusedWrBits;

  assign unusedWrBits = ^{wrData[REG_W-1:USED_W], wrData[RSV_BIT]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csVal    <= '0;
      clkVal   <= 1'b0;
      datVal   <= '0;
      csClkDir <= 1'b0;
      datDir   <= '0;
      ssb      <= 1'b0;
    end else begin
      if (strobe.cfgLd) begin
        csClkDir <= wrData[CSDIR_BIT];
        datDir   <= wrData[DIR_LSB +: DAT_LINES];
        ssb      <= wrData[SSB_BIT];
      end
      for (int i = 0; i < CS_LINES; i++)
        if (strobe.csLd[i]) csVal[i] <= wrData[CS_LSB + i];
      if (strobe.clkLd) clkVal <= wrData[CLK_BIT];
      for (int j = 0; j < DAT_LINES; j++)
        if (strobe.datLd[j]) datVal[j] <= wrData[DAT_LSB + j];
    end
  end

  spi_pad_sync #(.WIDTH(PAD_IN_W), .STAGES(SYNC_STAGES)) u_padSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({clkIn, datIn, csIn}),
    .syncOut (padSync)
  );

  assign csSync  = padSync[CS_LINES-1:0];
  assign datSync = padSync[CS_LINES +: DAT_LINES];
  assign clkSync = padSync[PAD_IN_W-1];

  always_comb begin
    rdData = '0;
    for (int i = 0; i < CS_LINES; i++)
      rdData[CS_LSB + i] = csClkDir ? csSync[i] : csVal[i];
    for (int j = 0; j < DAT_LINES; j++) begin
      rdData[DAT_LSB + j] = datDir[j] ? datSync[j] : datVal[j];
      rdData[DIR_LSB + j] = datDir[j];
    end
    rdData[CLK_BIT]   = csClkDir ? clkSync : clkVal;
    rdData[CSDIR_BIT] = csClkDir;
    rdData[SSB_BIT]   = ssb;
  end

  always_comb begin
    if (testMode) begin
      csOut  = csVal;
      csOe   = {CS_LINES{~csClkDir}};
      clkOut = clkVal;
      clkOe  = ~csClkDir;
      datOut = datVal;
      datOe  = ~datDir;
    end else begin
      csOut  = engCsOut;
      csOe   = engCsOe;
      clkOut = engClkOut;
      clkOe  = engClkOe;
      datOut = engDatOut;
      datOe  = engDatOe;
    end
  end

  assign setAllStatus   = ssb;
  assign blockStatusClr = ssb;
endmodule

// File: rtl/spi_pad_test_reg.sv
module spi_pad_test_reg
  import spi_pad_test_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 testMode,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  input  logic [CS_LINES-1:0]  engCsOut,
  input  logic [CS_LINES-1:0]  engCsOe,
  input  logic                 engClkOut,
  input  logic                 engClkOe,
  input  logic [DAT_LINES-1:0] engDatOut,
  input  logic [DAT_LINES-1:0] engDatOe,
  input  logic [CS_LINES-1:0]  csIn,
  input  logic                 clkIn,
  input  logic [DAT_LINES-1:0] datIn,
  output logic [CS_LINES-1:0]  csOut,
  output logic [CS_LINES-1:0]  csOe,
  output logic                 clkOut,
  output logic                 clkOe,
  output logic [DAT_LINES-1:0] datOut,
  output logic [DAT_LINES-1:0] datOe,
  output logic                 setAllStatus,
  output logic                 blockStatusClr
);
  padStrobe_t           strobe;
  logic                 csClkDir;
  logic [DAT_LINES-1:0] datDir;

  spi_pad_test_ctrl u_ctrl (
    .wrEn     (wrEn),
    .csClkDir (csClkDir),
    .datDir   (datDir),
    .strobe   (strobe)
  );

  spi_pad_test_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .testMode       (testMode),
    .strobe         (strobe),
    .wrData         (wrData),
    .rdData         (rdData),
    .csClkDir       (csClkDir),
    .datDir         (datDir),
    .engCsOut       (engCsOut),
    .engCsOe        (engCsOe),
    .engClkOut      (engClkOut),
    .engClkOe       (engClkOe),
    .engDatOut      (engDatOut),
    .engDatOe       (engDatOe),
    .csIn           (csIn),
    .clkIn          (clkIn),
    .datIn          (datIn),
    .csOut          (csOut),
    .csOe           (csOe),
    .clkOut         (clkOut),
    .clkOe          (clkOe),
    .datOut         (datOut),
    .datOe          (datOe),
    .setAllStatus   (setAllStatus),
    .blockStatusClr (blockStatusClr)
  );
endmodule

// File: rtl/spi_pad_test_chk.sv
module spi_pad_test_chk
  import spi_pad_test_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 testMode,
  input logic                 wrEn,
  input logic [REG_W-1:0]     wrData,
  input logic [REG_W-1:0]     rdData,
  input logic [CS_LINES-1:0]  engCsOut,
  input logic [CS_LINES-1:0]  engCsOe,
  input logic                 engClkOut,
  input logic                 engClkOe,
  input logic [DAT_LINES-1:0] engDatOut,
  input logic [DAT_LINES-1:0] engDatOe,
  input logic [CS_LINES-1:0]  csOut,
  input logic [CS_LINES-1:0]  csOe,
  input logic                 clkOut,
  input logic                 clkOe,
  input logic [DAT_LINES-1:0] datOut,
  input logic [DAT_LINES-1:0] datOe,
  input logic                 setAllStatus,
  input logic                 blockStatusClr
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:USED_W] == '0 && !rdData[RSV_BIT]);

  assert_cs_clk_oe_R3: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (csOe == {CS_LINES{~rdData[CSDIR_BIT]}}) && (clkOe == ~rdData[CSDIR_BIT]));

  assert_dat_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> datOe == ~rdData[DIR_LSB +: DAT_LINES]);

  assert_dat1_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn) && !$past(rdData[DIR_LSB+1]) && testMode |-> datOut[1] == $past(wrData[DAT_LSB+1]));

  assert_input_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    testMode && $past(testMode) && $past(rdData[CSDIR_BIT]) |-> $stable(csOut) && $stable(clkOut));

  assert_set_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    setAllStatus == rdData[SSB_BIT] && blockStatusClr == rdData[SSB_BIT]);

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> csOut == engCsOut && csOe == engCsOe && clkOut == engClkOut &&
                  clkOe == engClkOe && datOut == engDatOut && datOe == engDatOe);
endmodule

bind spi_pad_test_reg spi_pad_test_chk u_chk (.*);

// File: tb/spi_pad_test_reg_tb.sv
module spi_pad_test_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testMode = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  engCsOut = '0, engCsOe = '0;
  logic        engClkOut = 1'b0, engClkOe = 1'b0;
  logic [1:0]  engDatOut = '0, engDatOe = '0;
  logic [3:0]  csIn = '0;
  logic        clkIn = 1'b0;
  logic [1:0]  datIn = '0;
  logic [3:0]  csOut, csOe;
  logic        clkOut, clkOe;
  logic [1:0]  datOut, datOe;
  logic        setAllStatus, blockStatusClr;

  int checks = 0;
  int fails  = 0;

  // Bench model of the register state.
  logic [3:0] mCs = '0;
  logic       mClk = 1'b0;
  logic [1:0] mDat = '0;
  logic       mCsDir = 1'b0;
  logic [1:0] mDatDir = '0;
  logic       mSsb = 1'b0;

  always #4 clk = ~clk;

  spi_pad_test_reg u_dut (.*);

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRd();
    logic [31:0] r = '0;
    r[3:0]  = mCsDir ? csIn : mCs;
    r[4]    = mDatDir[0] ? datIn[0] : mDat[0];
    r[5]    = mDatDir[1] ? datIn[1] : mDat[1];
    r[6]    = mCsDir ? clkIn : mClk;
    r[9:8]  = mDatDir;
    r[10]   = mCsDir;
    r[11]   = mSsb;
    return r;
  endfunction

  task automatic checkAll();
    cmp("R1/R5/R6/R7 readback", rdData, expRd());
    if (testMode) begin
      cmp("R3/R5/R7 cs+clk out", {27'd0, clkOut, csOut}, {27'd0, mClk, mCs});
      cmp("R3 cs+clk oe", {27'd0, clkOe, csOe}, {27'd0, ~mCsDir, {4{~mCsDir}}});
      cmp("R4/R5 dat out+oe", {28'd0, datOe, datOut}, {28'd0, ~mDatDir, mDat});
    end else begin
      cmp("R9 bypass out", {25'd0, datOut, clkOut, csOut}, {25'd0, engDatOut, engClkOut, engCsOut});
      cmp("R9 bypass oe", {25'd0, datOe, clkOe, csOe}, {25'd0, engDatOe, engClkOe, engCsOe});
    end
    cmp("R8 set-all/block", {30'd0, setAllStatus, blockStatusClr}, {30'd0, mSsb, mSsb});
  endtask

  task automatic doWrite(input logic [31:0] w, input logic [6:0] pads, input logic [13:0] eng);
    @(negedge clk);
    csIn = pads[3:0]; datIn = pads[5:4]; clkIn = pads[6];
    {engCsOut, engCsOe, engClkOut, engClkOe, engDatOut, engDatOe} = eng;
    wrEn = 1'b1; wrData = w;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    // Model update uses the directions held before this write (R7).
    if (!mCsDir) begin mCs = w[3:0]; mClk = w[6]; end
    if (!mDatDir[0]) mDat[0] = w[4];
    if (!mDatDir[1]) mDat[1] = w[5];
    mCsDir = w[10]; mDatDir = w[9:8]; mSsb = w[11];
    // Immediate output-enable check on the edge after the write (R3).
    if (testMode) cmp("R3 oe after one edge", {31'd0, clkOe}, {31'd0, ~mCsDir});
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R2: reset state in test mode.
    cmp("R2 reset readback", rdData, 32'd0);
    cmp("R2 reset pads", {20'd0, setAllStatus, clkOe, csOe, datOe, clkOut, csOut, datOut},
        {20'd0, 1'b0, 1'b1, 4'hF, 2'b11, 1'b0, 4'h0, 2'b00});
    for (int pass = 0; pass < 2; pass++) begin
      testMode = (pass == 0);
      for (int i = 0; i < 1024; i++) begin
        logic [6:0]  v;
        logic [2:0]  d;
        logic [31:0] w;
        logic [6:0]  pads;
        logic [13:0] eng;
        v = 7'(i >> 3);
        d = 3'(i) ^ 3'(i >> 3);
        w = {v, v, v[5:0], (v[0] ^ d[1]), d, v[2], v};
        pads = 7'(i * 37 + 11);
        eng  = 14'(i * 613 + pass * 97);
        doWrite(w, pads, eng);
      end
    end
    // R8: set-all held over several idle cycles, then released.
    doWrite(32'h0000_0800, 7'h00, 14'd0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    cmp("R8 set-all held", {31'd0, setAllStatus}, 32'd1);
    doWrite(32'h0000_0000, 7'h7F, 14'd0);
    cmp("R8 set-all released", {31'd0, blockStatusClr}, 32'd0);
    report();
    $finish;
  end
endmodule